// File: doc/BRIEF.md
# Shadow Region Attribute Decoder

This block sits beside the memory path of a legacy-compatible chip and decides, for every access that falls in the upper 256 KB of the first megabyte (C0000h to FFFFFh), whether the cycle is served by on-board DRAM or forwarded to the external bus. Software programs four byte-wide settings through a plain write port. One global setting holds a read policy bit and a write policy bit. The other three hold one enable bit per 16 KB segment for the C, D and E regions. The top 64 KB segment (F0000h to FFFFFh) has no enable and always follows the global policy. A segment whose enable is clear sends both reads and writes out to the external bus.

Accesses arrive on a valid/ready request channel and leave as a registered decision on a valid/ready response channel, with a single output register. The request side is ready whenever the output register is empty or is being drained in the same cycle (`acc_ready = !rsp_valid || rsp_ready`). A stalled response holds all of its fields. The block also keeps a copy of every segment's last effective attribute and pulses a change mask for one cycle whenever any of those attributes changes, so a neighbouring cache or TLB can invalidate only the affected ranges.

Segments are numbered 0 to 12: C0000h + i×4000h is segment i, D0000h + i×4000h is 4+i, E0000h + i×4000h is 8+i, and the F region is 12.

Top module: `shadow_region_decoder`

## Requirements
- R1: After reset all four settings read as zero, `rsp_valid` and `upd_valid` are low, and the F region then reads from the external bus and writes to DRAM.
- R2: Setting index 0 is the policy: bit 6 set sends reads of enabled segments to DRAM (clear: external); bit 5 set sends writes to the external bus (clear: DRAM).
- R3: Accesses to F0000h–FFFFFh always follow the index 0 policy and report segment 12.
- R4: Index 1 enables the E region, index 2 the D region and index 3 the C region; within a byte, bit (7−i) enables the segment at region base + i×4000h, and an enabled segment follows the policy.
- R5: An access to a segment whose enable bit is clear gives `rsp_internal` = 0 for reads and writes, whatever the policy.
- R6: An address outside C0000h–FFFFFh gives `rsp_hit` = 0 and `rsp_internal` = 0; inside the range `rsp_hit` = 1 and `rsp_seg` is the segment number.
- R7: `acc_ready` equals `!rsp_valid || rsp_ready`; while `rsp_valid` is high and `rsp_ready` low, the response fields do not change.
- R8: An accepted request produces its response in the next cycle, decided with the settings in force before any setting write made in the same cycle.
- R9: One cycle after a setting write takes effect, `upd_valid` pulses for one cycle with `upd_mask` bit s set for exactly the segments whose effective read or write routing changed; a write that changes no routing gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_idx | input | 2 | Setting index (0 policy, 1 E, 2 D, 3 C enables) |
| cfg_wdata | input | 8 | Setting write data |
| acc_valid | input | 1 | Request valid |
| acc_ready | output | 1 | Request ready |
| acc_addr | input | 20 | Request address |
| acc_write | input | 1 | Request is a write (1) or a read (0) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_hit | output | 1 | Address lies in C0000h–FFFFFh |
| rsp_internal | output | 1 | Route to DRAM (1) or external bus (0) |
| rsp_seg | output | 4 | Segment number of the access |
| upd_valid | output | 1 | One-cycle attribute change pulse |
| upd_mask | output | 13 | Segments whose attribute changed |

## Verification
A setting write and a request can land in the same clock, and so can a change pulse and a response. The bench provokes this by driving a policy or enable write together with an access to the very segment it alters, and by doing so while the response channel is stalled. A behavioural model in the bench applies the write only after deciding the access and derives the change mask from its own previous attribute copy; every output is compared against it on every clock, which judges both the old-setting decision and the exact cycle and mask of the pulse.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int SUBS_PER_REGION = 4;
  localparam int EN_REGIONS      = 3;
  localparam int N_SEG           = EN_REGIONS * SUBS_PER_REGION + 1;
  localparam int SEG_W           = $clog2(N_SEG);
  localparam int TOP_SEG         = N_SEG - 1;
  localparam int CFG_W           = 8;
  localparam int RD_POL_BIT      = 6;
  localparam int WR_POL_BIT      = 5;

  typedef struct packed {
    logic rd_int;
    logic wr_int;
  } seg_attr_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       idx,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] policy,
  output logic [CFG_W-1:0] en_c,
  output logic [CFG_W-1:0] en_d,
  output logic [CFG_W-1:0] en_e
);
  logic [CFG_W-1:0] bank [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) bank[k] <= '0;
    end else if (we) begin
      bank[idx] <= wdata;
    end
  end

  assign policy = bank[0];
  assign en_e   = bank[1];
  assign en_d   = bank[2];
  assign en_c   = bank[3];

  // R4
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> bank[$past(idx)] == $past(wdata));
endmodule

// File: rtl/shadow_attr_map.sv
module shadow_attr_map
  import shadow_pkg::*;
(
  input  logic [CFG_W-1:0]            policy,
  input  logic [CFG_W-1:0]            en_c,
  input  logic [CFG_W-1:0]            en_d,
  input  logic [CFG_W-1:0]            en_e,
  output seg_attr_t [N_SEG-1:0]       attr_vec
);
  logic rd_pol;
  logic wr_pol;
  assign rd_pol = policy[RD_POL_BIT];
  assign wr_pol = ~policy[WR_POL_BIT];

  for (genvar r = 0; r < EN_REGIONS; r++) begin : g_region
    logic [CFG_W-1:0] en_byte;
    assign en_byte = (r == 0) ? en_c : (r == 1) ? en_d : en_e;
    for (genvar i = 0; i < SUBS_PER_REGION; i++) begin : g_sub
      localparam int SEG = r * SUBS_PER_REGION + i;
      assign attr_vec[SEG].rd_int = en_byte[CFG_W-1-i] & rd_pol;
      assign attr_vec[SEG].wr_int = en_byte[CFG_W-1-i] & wr_pol;
    end
  end

  assign attr_vec[TOP_SEG].rd_int = rd_pol;
  assign attr_vec[TOP_SEG].wr_int = wr_pol;
endmodule

// File: rtl/shadow_change_track.sv
module shadow_change_track
  import shadow_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  seg_attr_t [N_SEG-1:0]  attr_vec,
  output logic                   upd_valid,
  output logic [N_SEG-1:0]       upd_mask
);
  seg_attr_t [N_SEG-1:0] cache;
  logic [N_SEG-1:0]      diff;
  logic                  started;

  for (genvar s = 0; s < N_SEG; s++) begin : g_diff
    assign diff[s] = attr_vec[s] != cache[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache                   <= '0;
      cache[TOP_SEG].wr_int   <= 1'b1;
      upd_valid               <= 1'b0;
      upd_mask                <= '0;
      started                 <= 1'b0;
    end else begin
      cache     <= attr_vec;
      upd_valid <= |diff;
      upd_mask  <= diff;
      started   <= 1'b1;
    end
  end

  // R9
  cache_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> cache == $past(attr_vec));
endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   acc_write,
  input  seg_attr_t [N_SEG-1:0]  attr_vec,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_hit,
  output logic                   rsp_internal,
  output logic [SEG_W-1:0]       rsp_seg
);
  localparam logic [3:0] FIRST_REGION = 4'hC;
  localparam logic [3:0] LAST_REGION  = 4'hF;

  logic [3:0]       region;
  logic [1:0]       sub;
  logic             hit;
  logic [SEG_W-1:0] seg;
  seg_attr_t        sel;
  logic             route_int;
  logic             accept;

  assign region = acc_addr[ADDR_W-1 -: 4];
  assign sub    = acc_addr[ADDR_W-5 -: 2];
  assign hit    = region >= FIRST_REGION;
  assign seg    = (region == LAST_REGION) ? SEG_W'(TOP_SEG)
                                          : SEG_W'({region[1:0], sub});

  always_comb begin
    sel = '0;
    if (hit) sel = attr_vec[seg];
  end

  assign route_int = acc_write ? sel.wr_int : sel.rd_int;
  assign acc_ready = ~rsp_valid | rsp_ready;
  assign accept    = acc_valid & acc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_internal <= 1'b0;
      rsp_seg      <= '0;
    end else if (accept) begin
      rsp_valid    <= 1'b1;
      rsp_hit      <= hit;
      rsp_internal <= route_int;
      rsp_seg      <= hit ? seg : '0;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
      && $stable(rsp_internal) && $stable(rsp_seg));
  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready |=> rsp_valid);
  // R6
  miss_external_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_internal);
endmodule

// File: rtl/shadow_region_decoder.sv
module shadow_region_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_internal,
  output logic [SEG_W-1:0]  rsp_seg,
  output logic              upd_valid,
  output logic [N_SEG-1:0]  upd_mask
);
  logic [CFG_W-1:0]      policy, en_c, en_d, en_e;
  seg_attr_t [N_SEG-1:0] attr_vec;

  shadow_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .policy(policy), .en_c(en_c), .en_d(en_d), .en_e(en_e)
  );

  shadow_attr_map u_map (
    .policy(policy), .en_c(en_c), .en_d(en_d), .en_e(en_e), .attr_vec(attr_vec)
  );

  shadow_change_track u_track (
    .clk(clk), .rst_n(rst_n), .attr_vec(attr_vec),
    .upd_valid(upd_valid), .upd_mask(upd_mask)
  );

  shadow_route #(.ADDR_W(ADDR_W)) u_route (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .attr_vec(attr_vec),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_internal(rsp_internal), .rsp_seg(rsp_seg)
  );
endmodule

// File: tb/tb_shadow_region_decoder.sv
module tb_shadow_region_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        acc_valid = 0;
  logic        acc_ready;
  logic [19:0] acc_addr = 0;
  logic        acc_write = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic        rsp_hit, rsp_internal;
  logic [3:0]  rsp_seg;
  logic        upd_valid;
  logic [12:0] upd_mask;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";

  // reference model state
  int m_reg [4];
  int m_cache [13];
  bit m_rsp_valid = 0, m_hit = 0, m_int = 0;
  int m_seg = 0;
  bit m_upd_valid = 0;
  int m_upd_mask = 0;

  always #10 clk = ~clk;

  shadow_region_decoder dut (.*);

  function automatic int attr_of(int s);
    int en, pol;
    pol = m_reg[0];
    if (s == 12) en = 1;
    else begin
      int ri;
      ri = (s < 4) ? 3 : (s < 8) ? 2 : 1;
      en = (m_reg[ri] >> (7 - (s % 4))) & 1;
    end
    if (en == 0) return 0;
    return ((((pol >> 6) & 1)) << 1) | (((pol >> 5) & 1) ^ 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_reg[k] = 0;
      for (int s = 0; s < 13; s++) m_cache[s] = (s == 12) ? 1 : 0;
      m_rsp_valid = 0; m_hit = 0; m_int = 0; m_seg = 0;
      m_upd_valid = 0; m_upd_mask = 0;
    end else begin
      int msk;
      if (acc_valid && (!m_rsp_valid || rsp_ready)) begin
        int rg, sg, a;
        rg = int'(acc_addr) >> 16;
        m_rsp_valid = 1;
        if (rg < 12) begin
          m_hit = 0; m_int = 0; m_seg = 0;
        end else begin
          sg = (rg == 15) ? 12 : (rg - 12) * 4 + ((int'(acc_addr) >> 14) & 3);
          a = attr_of(sg);
          m_hit = 1; m_seg = sg;
          m_int = acc_write ? a[0] : a[1];
        end
      end else if (rsp_ready) m_rsp_valid = 0;
      msk = 0;
      for (int s = 0; s < 13; s++) begin
        int a;
        a = attr_of(s);
        if (a != m_cache[s]) msk |= (1 << s);
        m_cache[s] = a;
      end
      m_upd_mask = msk;
      m_upd_valid = (msk != 0);
      if (cfg_we) m_reg[cfg_idx] = int'(cfg_wdata);
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("acc_ready", acc_ready, (!m_rsp_valid || rsp_ready));
      chk("rsp_valid", rsp_valid, m_rsp_valid);
      if (m_rsp_valid) begin
        chk("rsp_hit", rsp_hit, m_hit);
        chk("rsp_internal", rsp_internal, m_int);
        chk("rsp_seg", rsp_seg, m_seg);
      end
      chk("upd_valid", upd_valid, m_upd_valid);
      chk("upd_mask", upd_mask, m_upd_mask);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(bit we, int idx, int d, bit av, int addr, bit wr);
    @(negedge clk);
    cfg_we = we; cfg_idx = idx[1:0]; cfg_wdata = d[7:0];
    acc_valid = av; acc_addr = addr[19:0]; acc_write = wr;
  endtask

  task automatic cfg(int idx, int d);
    step(1, idx, d, 0, 0, 0);
  endtask

  task automatic acc(int addr, bit wr);
    step(0, 0, 0, 1, addr, wr);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic sweep();
    for (int s = 0; s < 13; s++) begin
      int base;
      base = (s == 12) ? 32'hF0000 + 32'h4000 * (s % 3)
                       : 32'hC0000 + 32'h10000 * (s / 4) + 32'h4000 * (s % 4) + 32'h123;
      acc(base, 0);
      acc(base + 32'h3FFF - 32'h123, 1);
    end
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and default routing of F region
    phase = "R1";
    @(negedge clk); #2;
    chk("reset rsp_valid", rsp_valid, 0);
    chk("reset upd_valid", upd_valid, 0);
    acc(32'hF8000, 0); acc(32'hFFFFF, 1); idle(2);
    // R6: outside range
    phase = "R6";
    acc(32'h9FFFF, 0); acc(32'h00000, 1); acc(32'hBC000, 1); acc(32'hC0000, 0); idle(2);
    // R2 and R3: policy combinations on F region
    phase = "R2";
    cfg(0, 8'h40); idle(2); acc(32'hF0000, 0); acc(32'hF0000, 1);
    cfg(0, 8'h20); idle(2); acc(32'hF4000, 0); acc(32'hF4000, 1);
    phase = "R3";
    cfg(0, 8'h60); idle(2); sweep();
    cfg(0, 8'h9F); idle(2); sweep();
    // R4: enable patterns per region and bit order
    phase = "R4";
    cfg(0, 8'h40);
    cfg(3, 8'h80); idle(2); sweep();
    cfg(2, 8'hA5); cfg(1, 8'h3C); idle(2); sweep();
    cfg(3, 8'h1F); cfg(2, 8'h01); cfg(1, 8'hF0); idle(2); sweep();
    // R5: disabled segments ignore policy
    phase = "R5";
    cfg(1, 0); cfg(2, 0); cfg(3, 0); cfg(0, 8'h40); idle(2); sweep();
    cfg(0, 8'h00); idle(2); sweep();
    // R9: change pulses and a no-change write
    phase = "R9";
    cfg(3, 8'hFF); idle(3);
    cfg(3, 8'hFF); idle(3);
    cfg(0, 8'h40); idle(3);
    cfg(0, 8'h5F); idle(3);
    cfg(1, 8'h12); cfg(1, 8'h13); idle(3);
    // R8: setting write together with an access to the affected segment
    phase = "R8";
    step(1, 0, 8'h00, 1, 32'hC4000, 0);
    step(1, 0, 8'h40, 1, 32'hC4000, 0);
    step(1, 3, 8'h00, 1, 32'hC0000, 0);
    step(0, 0, 0, 1, 32'hC0000, 0);
    idle(3);
    // R7: back-pressure with a concurrent setting write
    phase = "R7";
    cfg(3, 8'hF0);
    rsp_ready = 0;
    acc(32'hC8000, 0); acc(32'hD0000, 1);
    step(1, 0, 8'h20, 1, 32'hE0000, 1);
    idle(2);
    rsp_ready = 1; idle(1);
    acc(32'hF0000, 1); rsp_ready = 0; acc(32'hC0000, 0); idle(2);
    rsp_ready = 1; acc(32'hC0000, 0); idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule